// File: doc/BRIEF.md
# USB Packet Bit Serializer

This block is the transmit half of a USB 2.0 transceiver macrocell's digital logic. An upstream protocol engine hands it one packet at a time as a stream of bytes over a valid/ready handshake. The block wraps the stream in a synchronisation preamble, shifts each byte out least significant bit first, inserts stuffed zeros so that no run of ones grows too long, NRZI-encodes the result, and closes the packet with an end-of-packet signal made of single-ended zeros.

The stream is transmitted exactly as received. The upstream side must place the packet identifier first and any CRC bytes last. A one-byte holding register sits in front of the shift register, so the next byte is already waiting when the current one finishes. The serial output moves only on a bit-rate enable strobe, which lets the block run from a fast core clock. Once the upstream side drops its valid signal, the ready signal stays low until the end-of-packet sequence has started and the block is idle again.

Top module: `usb_tx_serializer`

## Requirements
- R1: While reset is active and on the first clock after it, `sendReady` is 0, `lineOut` is 1 (idle J level) and `seZero` is 0.
- R2: Every packet begins with a preamble of seven 0 bits followed by one 1 bit. The first preamble bit appears on the first bit strobe after the packet start is accepted.
- R3: When `sendValid` rises while the block is idle, `sendReady` is still 0 in that cycle and is 1 in the very next cycle. The byte presented with the rising `sendValid` is the first byte sent after the preamble.
- R4: A byte is taken on each rising edge where `sendValid` and `sendReady` are both 1. Taken bytes go out unchanged, in order and least significant bit first. Nothing is added before or after them apart from the preamble, stuffed bits and end-of-packet.
- R5: After six consecutive 1 bits, a 0 bit is inserted. The run counts across byte boundaries and includes the final 1 of the preamble. A stuffed bit that is due after the last data bit is still sent before the end-of-packet.
- R6: NRZI coding: a 0 bit toggles `lineOut` and a 1 bit leaves it unchanged.
- R7: While `sendValid` stays high, consecutive bytes leave with no idle bit strobes between them.
- R8: Once `sendValid` is low and every data and stuffed bit has been sent, `seZero` is 1 for exactly two bit times. It is followed by one bit time of `lineOut` = 1 with `seZero` = 0, and then the block is idle.
- R9: Once `sendValid` is 0 while `sendReady` is 0, `sendReady` stays 0 until the end-of-packet has completed and the block is idle.
- R10: `lineOut` and `seZero` change only on clock edges where `bitEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | One-cycle strobe per serial bit time |
| sendValid | input | 1 | Upstream has a packet byte on `sendData`; low ends the packet |
| sendData | input | DATA_W | Packet byte, identifier first |
| sendReady | output | 1 | The byte on `sendData` is taken at the next rising edge if `sendValid` is high |
| lineOut | output | 1 | NRZI-coded serial bit, 1 = J level |
| seZero | output | 1 | High during the single-ended-zero part of end-of-packet |

## Verification
The assertions check the following on every cycle: `sendReady` stays withheld after the valid drop, ready arrives one cycle after a start from idle, a full holding register is never overwritten, the ones-run counter never exceeds the stuffing limit, the line returns to J when single-ended zero ends, and the outputs move only on bit strobes. Several properties can only be shown by the bench's scenarios, where a decoder turns the serial line back into bytes and compares them with a scoreboard. These are the preamble contents, the position of every stuffed bit (including across byte boundaries, after the preamble and just before end-of-packet), the exact end-of-packet length and the absence of gaps between bytes.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  // Transmit sequencer states
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SYNC  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_DWAIT = 3'd4,
    ST_EOP   = 3'd5
  } txState_t;

  // One-cycle strobes from the sequencer to the bit datapath
  typedef struct packed {
    logic loadSync;   // start of packet: load preamble into shifter
    logic takeByte;   // handshake completed: capture input byte
    logic startEop;   // all bits out: begin end-of-packet
  } txStrobe_t;

endpackage

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sendValid,
  input  logic      holdFull,
  input  logic      shiftBusy,
  input  logic      reloadNow,
  input  logic      eopDone,
  output txStrobe_t strobe,
  output logic      sendReady,
  output logic      inEop
);

  txState_t state, stateNext;
  logic     closing;
  logic     inPacket;
  logic     endReq;

  assign inPacket  = (state == ST_SYNC) || (state == ST_LOAD) || (state == ST_DWAIT);
  assign sendReady = inPacket && !holdFull && !closing;
  assign endReq    = closing || !sendValid;
  assign inEop     = (state == ST_EOP);

  always_comb begin
    strobe.loadSync = (state == ST_WAIT) && sendValid;
    strobe.takeByte = sendValid && sendReady;
    strobe.startEop = ((state == ST_SYNC) || (state == ST_LOAD)) &&
                      endReq && !holdFull && !shiftBusy;
    stateNext = state;
    case (state)
      ST_RESET: stateNext = ST_WAIT;
      ST_WAIT:  if (strobe.loadSync) stateNext = ST_SYNC;
      ST_SYNC: begin
        if (strobe.startEop)  stateNext = ST_EOP;
        else if (reloadNow)   stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        if (strobe.startEop)      stateNext = ST_EOP;
        else if (strobe.takeByte) stateNext = ST_DWAIT;
      end
      ST_DWAIT: if (reloadNow) stateNext = ST_LOAD;
      ST_EOP:   if (eopDone)   stateNext = ST_WAIT;
      default:  stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RESET;
      closing <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.loadSync)            closing <= 1'b0;
      else if (inPacket && !sendValid) closing <= 1'b1;
    end
  end

  // R9: ready stays withheld once the upstream side has let go
  a_r9_ready_withheld: assert property (@(posedge clk) disable iff (!rstN)
    (!sendValid && !sendReady) |=> !sendReady);

  // R3: a start from idle yields ready in the very next cycle
  a_r3_ready_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && sendValid) |=> sendReady);

endmodule

// File: rtl/usb_tx_datapath.sv
module usb_tx_datapath
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int SE0_BITS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  txStrobe_t         strobe,
  input  logic              inEop,
  input  logic [DATA_W-1:0] sendData,
  output logic              holdFull,
  output logic              shiftBusy,
  output logic              reloadNow,
  output logic              eopDone,
  output logic              lineOut,
  output logic              seZero
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam int EOP_W = $clog2(SE0_BITS + 1);
  localparam logic [DATA_W-1:0] SYNC_PAT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitIdx;
  logic              shiftValid;
  logic [RUN_W-1:0]  onesCnt;
  logic [EOP_W-1:0]  eopCnt;

  logic stuffNow, emitData, emitStuff, lastBit, eopTick;

  assign stuffNow  = (onesCnt == RUN_W'(STUFF_RUN));
  assign emitData  = bitEn && shiftValid && !stuffNow && !inEop;
  assign emitStuff = bitEn && stuffNow && !inEop;
  assign lastBit   = emitData && (bitIdx == CNT_W'(DATA_W - 1));
  assign reloadNow = holdFull && (!shiftValid || lastBit) && !strobe.loadSync;
  assign shiftBusy = shiftValid || stuffNow;
  assign eopTick   = inEop && bitEn;
  assign eopDone   = eopTick && (eopCnt == EOP_W'(SE0_BITS));

  // Holding register: filled by the handshake, drained into the shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (strobe.takeByte) begin
      holdReg  <= sendData;
      holdFull <= 1'b1;
    end else if (reloadNow) begin
      holdFull <= 1'b0;
    end
  end

  // Shift register, LSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      bitIdx     <= '0;
      shiftValid <= 1'b0;
    end else if (strobe.loadSync) begin
      shiftReg   <= SYNC_PAT;
      bitIdx     <= '0;
      shiftValid <= 1'b1;
    end else if (reloadNow) begin
      shiftReg   <= holdReg;
      bitIdx     <= '0;
      shiftValid <= 1'b1;
    end else if (emitData) begin
      shiftReg <= shiftReg >> 1;
      bitIdx   <= bitIdx + 1'b1;
      if (lastBit) shiftValid <= 1'b0;
    end
  end

  // Ones-run counter for bit stuffing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
    end else if (strobe.loadSync || emitStuff) begin
      onesCnt <= '0;
    end else if (emitData) begin
      onesCnt <= shiftReg[0] ? onesCnt + 1'b1 : '0;
    end
  end

  // NRZI line and end-of-packet sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut <= 1'b1;
      seZero  <= 1'b0;
      eopCnt  <= '0;
    end else begin
      if (strobe.startEop) eopCnt <= '0;
      else if (eopTick && eopCnt != EOP_W'(SE0_BITS)) eopCnt <= eopCnt + 1'b1;

      if (emitStuff || (emitData && !shiftReg[0])) lineOut <= ~lineOut;
      else if (eopDone) lineOut <= 1'b1;

      if (eopTick) seZero <= (eopCnt < EOP_W'(SE0_BITS));
    end
  end

  // R5: the run of ones never exceeds the stuffing limit
  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= RUN_W'(STUFF_RUN));

  // R4: a waiting byte is never overwritten before it reaches the shifter
  a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !reloadNow) |=> (holdFull && $stable(holdReg)));

  // R8: single-ended zero is followed by the J level
  a_r8_j_after_se0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seZero) |-> lineOut);

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int SE0_BITS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              sendValid,
  input  logic [DATA_W-1:0] sendData,
  output logic              sendReady,
  output logic              lineOut,
  output logic              seZero
);

  txStrobe_t strobe;
  logic holdFull, shiftBusy, reloadNow, eopDone, inEop;

  usb_tx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sendValid (sendValid),
    .holdFull  (holdFull),
    .shiftBusy (shiftBusy),
    .reloadNow (reloadNow),
    .eopDone   (eopDone),
    .strobe    (strobe),
    .sendReady (sendReady),
    .inEop     (inEop)
  );

  usb_tx_datapath #(
    .DATA_W    (DATA_W),
    .STUFF_RUN (STUFF_RUN),
    .SE0_BITS  (SE0_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .strobe    (strobe),
    .inEop     (inEop),
    .sendData  (sendData),
    .holdFull  (holdFull),
    .shiftBusy (shiftBusy),
    .reloadNow (reloadNow),
    .eopDone   (eopDone),
    .lineOut   (lineOut),
    .seZero    (seZero)
  );

  // R10: serial outputs move only on bit strobes
  a_r10_line_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(lineOut) && $stable(seZero)));

endmodule

// File: tb/usb_tx_serializer_bench.sv
module usb_tx_serializer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       sendValid = 1'b0;
  logic [7:0] sendData = 8'h00;
  logic       sendReady, lineOut, seZero;

  usb_tx_serializer u_usb_tx_serializer (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .sendValid(sendValid),
    .sendData(sendData), .sendReady(sendReady), .lineOut(lineOut), .seZero(seZero)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  int         lenQ[$];
  logic [7:0] pktBuf [0:15];

  // decoder state
  int         pktDone = 0;
  bit         inPkt = 1'b0;
  logic       prevLn = 1'b1;
  logic       lastLn = 1'b1;
  logic       lastSe = 1'b0;
  bit         r10Bad = 1'b0;
  int         ones, syncCnt, bitIdx, nBytes, se0Cnt;
  logic [7:0] syncVal, curByte;

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bitStep(input logic b);
    logic [7:0] exp;
    if (syncCnt < 8) begin
      syncVal[syncCnt[2:0]] = b;
      syncCnt++;
      ones = b ? ones + 1 : 0;
      if (syncCnt == 8) note(syncVal == 8'h80, "R2 R6", "preamble", syncVal, 8'h80);
      return;
    end
    if (ones == 6) begin
      note(b == 1'b0, "R5", "stuffed bit", b, 0);
      ones = 0;
      return;
    end
    ones = b ? ones + 1 : 0;
    curByte[bitIdx[2:0]] = b;
    bitIdx++;
    if (bitIdx == 8) begin
      exp = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
      note(curByte === exp, "R4", "recovered byte", curByte, exp);
      bitIdx = 0;
      nBytes++;
    end
  endtask

  task automatic decodeStep(input logic ln, input logic se);
    int expLen;
    if (!inPkt) begin
      if (se) note(1'b0, "R8", "single-ended zero while idle", 1, 0);
      else if (ln != prevLn) begin
        inPkt = 1'b1; syncCnt = 0; syncVal = 8'h00; ones = 0;
        bitIdx = 0; nBytes = 0; se0Cnt = 0; curByte = 8'h00;
        prevLn = ln;
        bitStep(1'b0);
      end
      return;
    end
    if (se) begin
      se0Cnt++;
      return;
    end
    if (se0Cnt > 0) begin
      expLen = (lenQ.size() > 0) ? lenQ.pop_front() : -1;
      note(se0Cnt == 2 && ln == 1'b1, "R8", "end-of-packet shape", se0Cnt, 2);
      note(bitIdx == 0 && nBytes == expLen, "R7", "byte count without gaps", nBytes, expLen);
      note(ones != 6, "R5", "trailing stuff before end-of-packet", ones, 0);
      note(!r10Bad, "R10", "output moved without strobe", r10Bad, 0);
      r10Bad = 1'b0;
      inPkt = 1'b0;
      prevLn = ln;
      pktDone++;
      return;
    end
    bitStep(ln == prevLn);  // R6: no change decodes as 1
    prevLn = ln;
  endtask

  // bit strobe generator and line monitor
  initial begin
    int divCnt = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!bitEn && (lineOut != lastLn || seZero != lastSe)) r10Bad = 1'b1;
        if (bitEn) decodeStep(lineOut, seZero);
      end
      lastLn = lineOut;
      lastSe = seZero;
      divCnt = (divCnt == BIT_DIV - 1) ? 0 : divCnt + 1;
      bitEn = (divCnt == 0);
    end
  end

  task automatic sendPacket(input int n);
    int startDone = pktDone;
    int waits = 0;
    bit bad = 1'b0;
    lenQ.push_back(n);
    @(negedge clk);
    sendValid = 1'b1;
    sendData  = pktBuf[0];
    note(!sendReady, "R3", "ready low as valid rises", sendReady, 0);
    for (int i = 0; i < n; i++) begin
      sendData = pktBuf[i];
      while (!sendReady) begin
        @(negedge clk);
        waits++;
      end
      if (i == 0) note(waits == 1, "R3", "ready latency in cycles", waits, 1);
      expQ.push_back(pktBuf[i]);
      @(posedge clk);
      @(negedge clk);
    end
    sendValid = 1'b0;
    sendData  = 8'h00;
    while (pktDone == startDone) begin
      if (sendReady) bad = 1'b1;
      @(negedge clk);
    end
    note(!bad, "R9", "ready withheld until idle", bad, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    note(!sendReady && lineOut && !seZero, "R1", "outputs in reset",
         {sendReady, lineOut, seZero}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    note(!sendReady && lineOut && !seZero, "R1", "outputs after reset",
         {sendReady, lineOut, seZero}, 3'b010);
    repeat (4) @(negedge clk);

    pktBuf[0] = 8'hA5;
    sendPacket(1);

    pktBuf[0] = 8'hC3; pktBuf[1] = 8'hFF; pktBuf[2] = 8'hFF;
    pktBuf[3] = 8'h00; pktBuf[4] = 8'h7E;
    sendPacket(5);

    // R5: preamble's final 1 starts the run
    pktBuf[0] = 8'h3F; pktBuf[1] = 8'h81;
    sendPacket(2);

    // R5: stuffed bit due right before end-of-packet
    pktBuf[0] = 8'h2D; pktBuf[1] = 8'hFC;
    sendPacket(2);

    // R7: long back-to-back stream
    for (int i = 0; i < 12; i++) pktBuf[i] = 8'(i * 37 + 5);
    sendPacket(12);

    note(expQ.size() == 0 && pktDone == 5, "R4", "all packets recovered", pktDone, 5);
    note(lineOut && !seZero && !sendReady, "R8", "idle after last packet",
         {sendReady, lineOut, seZero}, 3'b010);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", pktDone, 5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule